// File: doc/BRIEF.md
# Dual-Input Capture Timer

This block is a 16-bit free-running up-counter with two capture registers, used to measure the pulse widths of two independent input signals at the same time. Each input goes through a synchronizer and a digital noise filter. The filter samples the input on a prescaler tick, and it accepts a new level only after that level appears on two consecutive samples. When an accepted level change matches the edge chosen for that input, the current counter value is stored in a capture register and a one-cycle interrupt pulse is raised.

The connection between inputs and registers is crossed. Input `sense0_i` stores into capture register 1 and pulses `irq1_o`. Input `sense1_i` stores into capture register 0 and pulses `irq0_o`. Software subtracts two captures taken on one input to get a pulse width in ticks.

Software uses a simple write-strobe register port, and reads are combinational.

| Address | Contents |
|---|---|
| 0 | Mode register: bit 0 is the overflow flag, bit 1 is a spare enable, bits [3:2] are the run mode |
| 1 | Capture control, bits [2:0] |
| 2 | Prescaler register: bits [1:0] are the tick divider, bits [5:4] are the edge select for `sense0_i`, bits [7:6] are the edge select for `sense1_i` |
| 3 | Counter (read only) |
| 4 | Capture register 0 (read only) |
| 5 | Capture register 1 (read only) |

Top module: `dual_capture_timer`

## Requirements
- R1: After reset, every readable register (addresses 0 to 5) reads 0x0000, and both interrupt outputs are low.
- R2: When mode bits [3:2] of address 0 equal 2'b01, the counter adds 1 on each tick. It wraps from 0xFFFF to 0x0000, and a capture never clears it. Any other value of bits [3:2] holds the counter. Bit 1 has no effect on counting and reads back as written.
- R3: The overflow flag (address 0, bit 0) is set when the counter wraps. A write to address 0 with bit 0 = 0 clears the flag. A write with bit 0 = 1 leaves the flag unchanged.
- R4: Prescaler bits [1:0] of address 2 select the tick rate: 00 is clk/1, 01 is clk/4, 10 is clk/16 and 11 is clk/64. Both the counter and the input samplers advance only on a tick.
- R5: A valid edge on `sense0_i` copies the counter into capture register 1 (address 5) and pulses `irq1_o` for one cycle. Capture register 0 and `irq0_o` are not affected.
- R6: A valid edge on `sense1_i` copies the counter into capture register 0 (address 4) and pulses `irq0_o` for one cycle. Capture register 1 and `irq1_o` are not affected.
- R7: The edge-select field of each input is encoded as follows: 2'b00 is falling only, 2'b01 is rising only, 2'b10 never captures, and 2'b11 is both edges.
- R8: A level change is accepted only after it is seen on two consecutive tick samples. A pulse shorter than one tick period never causes a capture.
- R9: Captures and interrupts occur only when capture control bits [2:0] of address 1 equal 3'b101. Any other value suppresses both.
- R10: If both inputs produce valid edges on the same tick, both captures occur in that cycle, store the same counter value, and both interrupts pulse together.
- R11: A capture register holds its value until its next valid capture, and reading it has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address (0 to 5) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| sense0_i | input | 1 | Input 0; captures into register 1 |
| sense1_i | input | 1 | Input 1; captures into register 0 |
| irq0_o | output | 1 | One-cycle pulse on a capture into register 0 |
| irq1_o | output | 1 | One-cycle pulse on a capture into register 1 |

## Verification
The assertions check the following on every cycle:
- the counter steps by one on each running tick and holds when the mode is not running;
- the overflow flag is set after a wrap;
- each interrupt coincides with its register holding the previous counter value, and only when capture control allows it;
- filter edges occur only on ticks, always flip the accepted level, and never occur for the reserved edge code.

The bench's scenarios are needed to show the behaviour that spans many cycles: whole-pulse behaviour under every divider and edge code, the rejection of glitches shorter than one tick, measured pulse widths in ticks, simultaneous captures on both inputs, and the way the overflow flag responds to software writes.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_NONE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam logic [1:0] MODE_FREE   = 2'b01;
  localparam logic [2:0] CAPCTL_DUAL = 3'b101;

  localparam logic [2:0] ADDR_MODE   = 3'd0;
  localparam logic [2:0] ADDR_CAPCTL = 3'd1;
  localparam logic [2:0] ADDR_PRESC  = 3'd2;
  localparam logic [2:0] ADDR_CNT    = 3'd3;
  localparam logic [2:0] ADDR_CAP0   = 3'd4;
  localparam logic [2:0] ADDR_CAP1   = 3'd5;
endpackage

// File: rtl/dct_tick_gen.sv
module dct_tick_gen #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  // each select step divides by 4 more
  localparam int DIV_W = 2 * ((1 << SEL_W) - 1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  assign mask   = ~({DIV_W{1'b1}} << (2 * sel_i));
  assign tick_o = ((div_q & mask) == '0);

  assert_fast_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |-> tick_o);
endmodule

// File: rtl/dct_pin_filter.sv
module dct_pin_filter import dct_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  logic      tick_i,
  input  logic [1:0] sel_i,
  output logic      edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   smp;
  logic                   prev_q;
  logic                   lvl_q;
  logic                   accept;
  logic                   match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign smp = sync_q[SYNC_STAGES-1];

  // new level must match the previous tick sample
  assign accept = tick_i && (smp == prev_q) && (smp != lvl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else if (tick_i) begin
      prev_q <= smp;
      if (accept) lvl_q <= smp;
    end
  end

  always_comb begin
    unique case (sel_i)
      EDGE_FALL: match = !smp;
      EDGE_RISE: match = smp;
      EDGE_BOTH: match = 1'b1;
      default:   match = 1'b0;
    endcase
  end

  assign edge_o = accept && match;

  assert_edge_on_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> tick_i);
  assert_level_flips_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (lvl_q != $past(lvl_q)));
  assert_reserved_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == EDGE_NONE) |-> !edge_o);
endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer import dct_pkg::*; #(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 3,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sense0_i,
  input  logic              sense1_i,
  output logic              irq0_o,
  output logic              irq1_o
);
  localparam int NUM_CH = 2;

  logic [2:0]       mode_q;     // mode register bits [3:1]
  logic             ovf_q;
  logic [2:0]       capctl_q;
  logic [SEL_W-1:0] div_sel_q;
  logic [1:0]       edge_sel_q [NUM_CH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cap_q [NUM_CH];
  logic [NUM_CH-1:0] irq_q;
  logic [NUM_CH-1:0] pin_vec;
  logic [NUM_CH-1:0] pin_edge;
  logic [NUM_CH-1:0] cap_hit;
  logic             tick;
  logic             run;
  logic             cap_en;
  logic             wrap;
  logic             wr_mode, wr_capctl, wr_presc;
  logic             unused_wdata;

  assign unused_wdata = ^{wdata_i[DATA_W-1:8], wdata_i[3:2]};

  assign wr_mode   = wr_en_i && (addr_i == ADDR_MODE);
  assign wr_capctl = wr_en_i && (addr_i == ADDR_CAPCTL);
  assign wr_presc  = wr_en_i && (addr_i == ADDR_PRESC);

  assign run    = (mode_q[2:1] == MODE_FREE);
  assign cap_en = (capctl_q == CAPCTL_DUAL);
  assign wrap   = run && tick && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      capctl_q  <= '0;
      div_sel_q <= '0;
      for (int i = 0; i < NUM_CH; i++) edge_sel_q[i] <= '0;
    end else begin
      if (wr_mode)   mode_q   <= wdata_i[3:1];
      if (wr_capctl) capctl_q <= wdata_i[2:0];
      if (wr_presc) begin
        div_sel_q     <= wdata_i[SEL_W-1:0];
        edge_sel_q[0] <= wdata_i[5:4];
        edge_sel_q[1] <= wdata_i[7:6];
      end
    end
  end

  // set wins over a clearing write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ovf_q <= 1'b0;
    else if (wrap)                    ovf_q <= 1'b1;
    else if (wr_mode && !wdata_i[0])  ovf_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (run && tick) cnt_q <= cnt_q + 1'b1;
  end

  dct_tick_gen #(.SEL_W(SEL_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (div_sel_q),
    .tick_o (tick)
  );

  assign pin_vec = {sense1_i, sense0_i};

  for (genvar p = 0; p < NUM_CH; p++) begin : g_pin
    dct_pin_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_vec[p]),
      .tick_i (tick),
      .sel_i  (edge_sel_q[p]),
      .edge_o (pin_edge[p])
    );
  end

  // crossed routing: register k is fed by the opposite pin
  for (genvar k = 0; k < NUM_CH; k++) begin : g_cap
    assign cap_hit[k] = cap_en && pin_edge[NUM_CH-1-k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cap_q[k] <= '0;
        irq_q[k] <= 1'b0;
      end else begin
        irq_q[k] <= cap_hit[k];
        if (cap_hit[k]) cap_q[k] <= cnt_q;
      end
    end

    assert_cap_value_R5_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q[k] |-> (cap_q[k] == $past(cnt_q)));
    assert_cap_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q[k] |-> $past(cap_en));
    assert_cap_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_q[k] |-> (cap_q[k] == $past(cap_q[k])));
  end

  assign irq0_o = irq_q[0];
  assign irq1_o = irq_q[1];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_MODE:   rdata_o[3:0]       = {mode_q, ovf_q};
      ADDR_CAPCTL: rdata_o[2:0]       = capctl_q;
      ADDR_PRESC:  rdata_o[7:0]       = {edge_sel_q[1], edge_sel_q[0], 2'b00, div_sel_q};
      ADDR_CNT:    rdata_o[CNT_W-1:0] = cnt_q;
      ADDR_CAP0:   rdata_o[CNT_W-1:0] = cap_q[0];
      ADDR_CAP1:   rdata_o[CNT_W-1:0] = cap_q[1];
      default:     rdata_o            = '0;
    endcase
  end

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tick) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_count_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run && tick) |=> $stable(cnt_q));
  assert_no_overflow_loss_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> ovf_q);
endmodule

// File: tb/dual_capture_timer_bench.sv
`timescale 1ns/1ps
module dual_capture_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        s0 = 1'b0, s1 = 1'b0;
  logic        irq0, irq1;

  int n_chk = 0, n_fail = 0;
  int n_irq0 = 0, n_irq1 = 0;
  bit both_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_capture_timer u_dual_capture_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sense0_i(s0), .sense1_i(s1),
    .irq0_o(irq0), .irq1_o(irq1)
  );

  always @(posedge clk) begin
    if (irq0) n_irq0++;
    if (irq1) n_irq1++;
    if (irq0 && irq1) both_seen = 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = 3'(a);
    #1;
    v = int'(rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    int v, a, b, c_pre, c_hi, c_lo, o_pre, o_post, i_pre, i_oth, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < 6; r++) begin
      rd(r, v);
      chk(v == 0, "R1 reset read", v, 0);
    end
    chk(!irq0 && !irq1, "R1 irq low", int'({irq1, irq0}), 0);

    wr(0, 16'h4);
    wr(1, 16'h5);

    // sweep: divider x input x edge code (other input set to both edges)
    for (int dv = 0; dv < 4; dv++) begin
      for (int p = 0; p < 2; p++) begin
        for (int es = 0; es < 4; es++) begin
          n = 1 << (2 * dv);
          if (p == 0) wr(2, (3 << 6) | (es << 4) | dv);
          else        wr(2, (es << 6) | (3 << 4) | dv);
          idle(4 * n + 4);
          rd(p == 0 ? 5 : 4, c_pre);
          rd(p == 0 ? 4 : 5, o_pre);
          i_pre = (p == 0) ? n_irq1 : n_irq0;
          i_oth = (p == 0) ? n_irq0 : n_irq1;
          if (p == 0) s0 = 1'b1; else s1 = 1'b1;
          idle(8 * n);
          rd(p == 0 ? 5 : 4, c_hi);
          if (p == 0) s0 = 1'b0; else s1 = 1'b0;
          idle(8 * n);
          rd(p == 0 ? 5 : 4, c_lo);
          rd(p == 0 ? 4 : 5, o_post);
          a = ((p == 0) ? n_irq1 : n_irq0) - i_pre;
          b = (es == 0 || es == 1) ? 1 : (es == 2) ? 0 : 2;
          chk(a == b, p == 0 ? "R7 R5 irq1 count" : "R7 R6 irq0 count", a, b);
          a = ((p == 0) ? n_irq0 : n_irq1) - i_oth;
          chk(a == 0, p == 0 ? "R5 other irq" : "R6 other irq", a, 0);
          chk(o_post == o_pre, p == 0 ? "R5 other reg" : "R6 other reg", o_post, o_pre);
          if (es == 3)
            chk(((c_lo - c_hi) & 16'hFFFF) == 8, "R4 R2 width ticks", (c_lo - c_hi) & 16'hFFFF, 8);
          if (es == 1)
            chk(c_lo == c_hi, "R11 hold after rise", c_lo, c_hi);
          if (es == 2)
            chk(c_lo == c_pre && c_hi == c_pre, "R7 reserved", c_lo, c_pre);
          if (es == 0)
            chk(c_hi == c_pre, "R7 no capture on rise", c_hi, c_pre);
        end
      end
    end

    // R8 glitch filter
    wr(2, (3 << 6) | (3 << 4) | 0);
    idle(8);
    i_pre = n_irq1;
    s0 = 1'b1; idle(1); s0 = 1'b0; idle(10);
    chk(n_irq1 - i_pre == 0, "R8 one-cycle glitch at div1", n_irq1 - i_pre, 0);
    i_pre = n_irq1;
    s0 = 1'b1; idle(2); s0 = 1'b0; idle(10);
    chk(n_irq1 - i_pre == 2, "R8 two-sample pulse at div1", n_irq1 - i_pre, 2);
    wr(2, (3 << 6) | (3 << 4) | 1);
    idle(16);
    i_pre = n_irq1;
    s0 = 1'b1; idle(3); s0 = 1'b0; idle(24);
    chk(n_irq1 - i_pre == 0, "R8 short glitch at div4", n_irq1 - i_pre, 0);
    i_pre = n_irq1;
    s0 = 1'b1; idle(8); s0 = 1'b0; idle(24);
    chk(n_irq1 - i_pre == 2, "R8 long pulse at div4", n_irq1 - i_pre, 2);

    // R9 capture control gate
    wr(2, (3 << 6) | (3 << 4) | 0);
    wr(1, 0);
    idle(6);
    rd(4, c_pre);
    i_pre = n_irq0;
    s1 = 1'b1; idle(8); s1 = 1'b0; idle(10);
    rd(4, v);
    chk(n_irq0 - i_pre == 0, "R9 irq suppressed", n_irq0 - i_pre, 0);
    chk(v == c_pre, "R9 register unchanged", v, c_pre);
    wr(1, 5);
    idle(4);

    // R10 simultaneous edges
    chk(both_seen == 0, "R10 no joint pulse yet", int'(both_seen), 0);
    s0 = 1'b1; s1 = 1'b1; idle(10);
    rd(4, a); rd(5, b);
    chk(both_seen == 1, "R10 joint pulse", int'(both_seen), 1);
    chk(a == b, "R10 equal captures", a, b);
    s0 = 1'b0; s1 = 1'b0; idle(10);

    // R11 read has no side effect
    rd(4, a); rd(4, b); rd(5, v); rd(4, c_lo);
    chk(a == b && b == c_lo, "R11 repeated read", c_lo, a);

    // R2 counting rate, mode hold, spare bit
    wr(2, 2);
    rd(3, a); idle(160); rd(3, b);
    chk(((b - a) & 16'hFFFF) == 10, "R4 R2 div16 count", (b - a) & 16'hFFFF, 10);
    wr(0, 0);
    rd(3, a); idle(50); rd(3, b);
    chk(a == b, "R2 stopped mode holds", b, a);
    wr(0, 6);
    wr(2, 0);
    rd(0, v);
    chk(v == 6, "R2 spare bit readback", v, 6);
    rd(3, a); idle(37); rd(3, b);
    chk(((b - a) & 16'hFFFF) == 37, "R2 spare bit no effect", (b - a) & 16'hFFFF, 37);

    // R3 overflow flag
    wr(0, 4);
    rd(0, v);
    chk((v & 1) == 0, "R3 flag clear before wrap", v & 1, 0);
    rd(3, a);
    idle(65536 - a + 4);
    rd(0, v);
    chk((v & 1) == 1, "R3 flag set on wrap", v & 1, 1);
    rd(3, b);
    chk(b < a, "R2 wrapped counter", b, a);
    wr(0, 5);
    rd(0, v);
    chk((v & 1) == 1, "R3 write one keeps flag", v & 1, 1);
    wr(0, 4);
    rd(0, v);
    chk((v & 1) == 0, "R3 write zero clears flag", v & 1, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule